// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block is a host-side bus master that loads a page of bytes into a byte-wide parallel EEPROM and then waits for the device's internal programming to finish. A client raises a start command with a base address and a byte count. It then hands over the bytes one at a time on a valid/ready stream. The sequencer drives the memory's active-low chip-enable, write-enable and output-enable lines, the address bus and the data bus. Each byte gets a setup phase and a write pulse whose lengths are set by parameters.

The memory keeps a page open only while write pulses arrive close enough together. The sequencer therefore keeps track of the time since the last write-enable falling edge. If the stream cannot supply the next byte before the allowed gap runs out, the sequencer abandons the page and flags an error. While the first byte has not yet been written, no gap limit applies. After the last byte it repeatedly reads back that byte's address. While the memory is still programming, it returns bit 7 inverted. Completion is reported when bit 7 matches the written value. A timeout is reported after a configured number of reads without a match.

Top module: `eeprom_page_writer`

## Requirements
- R1: After a start, the block performs exactly len_m1+1 write cycles. They go to addresses base, base+1, … in ascending order, and each carries the next stream byte in arrival order.
- R2: Whenever write-enable is low, chip-enable is low, output-enable is high and the data bus drive is enabled.
- R3: Each write cycle holds chip-enable low with write-enable and output-enable high for exactly SETUP_CYC cycles, then holds write-enable low for exactly PULSE_CYC cycles.
- R4: Within one page, successive write-enable falling edges are never more than GAP_MAX cycles apart.
- R5: While it waits for a byte after the first one, the block accepts a byte up to the cycle in which the gap since the last falling edge equals GAP_MAX-SETUP_CYC-1. If no byte has arrived by then, it pulses error_o for one cycle, performs no further write or read, and returns to idle.
- R6: Every polling read holds chip-enable and output-enable low and write-enable high, addresses the last byte written, and keeps the data bus drive disabled. The first read begins in the cycle right after the final write pulse.
- R7: At the end of each RD_CYC-cycle read, poll_bit_i is compared with bit 7 of the last byte. On a match, done_o pulses for one cycle. With B mismatching reads before the match (B < POLL_MAX), exactly B+1 reads are made.
- R8: If POLL_MAX reads all mismatch, timeout_o pulses for one cycle after the last of them, and no further read is made. At most one of done_o, timeout_o and error_o is high in any cycle.
- R9: A start asserted while a page is in progress is ignored and causes no extra write.
- R10: After reset all three strobes are high, the data drive is off, s_ready_o is low and all result flags are low.
- R11: Before the first byte of a page is written, the block waits for it without any time limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a page (sampled while idle) |
| base_i | input | AW | Address of the first byte |
| len_m1_i | input | log2(PAGE_BYTES) | Byte count minus one |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Block can take a stream byte |
| ce_n_o | output | 1 | Memory chip-enable, active low |
| we_n_o | output | 1 | Memory write-enable, active low |
| oe_n_o | output | 1 | Memory output-enable, active low |
| addr_o | output | AW | Memory address |
| dq_o | output | 8 | Data driven to memory |
| dq_oe_o | output | 1 | Data bus drive enable |
| poll_bit_i | input | 1 | Bit 7 of the memory data bus |
| done_o | output | 1 | One-cycle pulse: programming finished |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached |
| error_o | output | 1 | One-cycle pulse: page aborted on stream underrun |

## Verification
The bench builds the block with AW=10, PAGE_BYTES=16, SETUP_CYC=2, PULSE_CYC=3, RD_CYC=2, GAP_MAX=12 and POLL_MAX=6. With a 16-byte page, a completely full page fits in a short run. POLL_MAX=6 allows both the last successful read (five busy reads, then a match) and an exact timeout. GAP_MAX=12 leaves a stall window of exactly six idle load cycles after a pulse. The bench therefore drives one stall that just meets the limit and one that is a single cycle over it.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_SETUP = 3'd2,
        ST_PULSE = 3'd3,
        ST_READ  = 3'd4,
        ST_REST  = 3'd5
    } pw_state_e;

endpackage

// File: rtl/pw_gap_guard.sv
// Tracks cycles since the latest write-enable falling edge and flags the
// last load cycle in which a byte can still be accepted.
module pw_gap_guard #(
    parameter int GAP_MAX   = 40,
    parameter int SETUP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic last_o
);
    localparam int GW   = $clog2(GAP_MAX + 1);
    localparam int LAST = GAP_MAX - SETUP_CYC - 1;

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || restart_i) begin
            cnt_d = '0;
        end else if (cnt_q != GW'(GAP_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == GW'(LAST));

endmodule

// File: rtl/pw_poll_judge.sv
// Judges each polling read and counts reads that did not match.
module pw_poll_judge #(
    parameter int POLL_MAX = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sample_i,
    input  logic rd_bit_i,
    input  logic want_bit_i,
    output logic match_o,
    output logic exhaust_o
);
    localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    assign match_o   = sample_i && (rd_bit_i == want_bit_i);
    assign exhaust_o = sample_i && !match_o && (cnt_q == PW'(POLL_MAX - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                   cnt_d = '0;
        else if (sample_i && !match_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int AW         = 17,
    parameter int PAGE_BYTES = 128,
    parameter int SETUP_CYC  = 2,
    parameter int PULSE_CYC  = 4,
    parameter int RD_CYC     = 3,
    parameter int GAP_MAX    = 40,
    parameter int POLL_MAX   = 4096,
    localparam int LW        = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] len_m1_i,
    input  logic          s_valid_i,
    input  logic [7:0]    s_data_i,
    output logic          s_ready_o,
    output logic          ce_n_o,
    output logic          we_n_o,
    output logic          oe_n_o,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    dq_o,
    output logic          dq_oe_o,
    input  logic          poll_bit_i,
    output logic          done_o,
    output logic          timeout_o,
    output logic          error_o
);
    localparam int PH_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int PH_MAX = (PH_A > RD_CYC) ? PH_A : RD_CYC;
    localparam int TW     = $clog2(PH_MAX + 1);

    typedef struct packed {
        pw_state_e     st;
        logic [TW-1:0] tmr;
        logic [AW-1:0] base;
        logic [LW-1:0] idx;
        logic [LW-1:0] last;
        logic [7:0]    data;
        logic          first;
        logic          done;
        logic          tout;
        logic          err;
    } regs_t;

    localparam regs_t RST = '0;

    regs_t r_d, r_q;
    logic  gap_last, gap_restart, gap_run;
    logic  poll_match, poll_exhaust, poll_clear, poll_sample;

    assign gap_restart = (r_q.st == ST_SETUP) && (r_q.tmr == '0);
    assign gap_run     = (r_q.st != ST_IDLE);
    assign poll_clear  = !((r_q.st == ST_READ) || (r_q.st == ST_REST));
    assign poll_sample = (r_q.st == ST_READ) && (r_q.tmr == '0);

    pw_gap_guard #(
        .GAP_MAX   (GAP_MAX),
        .SETUP_CYC (SETUP_CYC)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (gap_restart),
        .run_i     (gap_run),
        .last_o    (gap_last)
    );

    pw_poll_judge #(
        .POLL_MAX (POLL_MAX)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (poll_clear),
        .sample_i   (poll_sample),
        .rd_bit_i   (poll_bit_i),
        .want_bit_i (r_q.data[7]),
        .match_o    (poll_match),
        .exhaust_o  (poll_exhaust)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tout = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_LOAD;
                    r_d.base  = base_i;
                    r_d.last  = len_m1_i;
                    r_d.idx   = '0;
                    r_d.first = 1'b1;
                end
            end
            ST_LOAD: begin
                if (s_valid_i) begin
                    r_d.st   = ST_SETUP;
                    r_d.data = s_data_i;
                    r_d.tmr  = TW'(SETUP_CYC - 1);
                end else if (!r_q.first && gap_last) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_SETUP: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_PULSE;
                    r_d.tmr = TW'(PULSE_CYC - 1);
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_PULSE: begin
                if (r_q.tmr == '0) begin
                    r_d.first = 1'b0;
                    if (r_q.idx == r_q.last) begin
                        r_d.st  = ST_READ;
                        r_d.tmr = TW'(RD_CYC - 1);
                    end else begin
                        r_d.st  = ST_LOAD;
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_READ: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else if (poll_match) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (poll_exhaust) begin
                    r_d.st   = ST_IDLE;
                    r_d.tout = 1'b1;
                end else begin
                    r_d.st = ST_REST;
                end
            end
            ST_REST: begin
                r_d.st  = ST_READ;
                r_d.tmr = TW'(RD_CYC - 1);
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign s_ready_o = (r_q.st == ST_LOAD);
    assign ce_n_o    = !((r_q.st == ST_SETUP) || (r_q.st == ST_PULSE) || (r_q.st == ST_READ));
    assign we_n_o    = (r_q.st != ST_PULSE);
    assign oe_n_o    = (r_q.st != ST_READ);
    assign dq_oe_o   = (r_q.st == ST_SETUP) || (r_q.st == ST_PULSE);
    assign dq_o      = r_q.data;
    assign addr_o    = r_q.base + AW'(r_q.idx);
    assign done_o    = r_q.done;
    assign timeout_o = r_q.tout;
    assign error_o   = r_q.err;

endmodule

// File: rtl/eeprom_pw_checker.sv
module eeprom_pw_checker #(
    parameter int GAP_MAX = 40
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n_o,
    input logic we_n_o,
    input logic oe_n_o,
    input logic dq_oe_o,
    input logic s_ready_o,
    input logic done_o,
    input logic timeout_o,
    input logic error_o
);
    localparam int DW = $clog2(GAP_MAX + 2) + 1;

    logic [DW-1:0] dist_q;
    logic          armed_q;
    logic          we_prev_q;
    logic          we_fell;

    assign we_fell = we_prev_q && !we_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dist_q    <= '0;
            armed_q   <= 1'b0;
            we_prev_q <= 1'b1;
        end else begin
            we_prev_q <= we_n_o;
            if (we_fell)                          dist_q <= DW'(1);
            else if (dist_q != DW'(GAP_MAX + 1))  dist_q <= dist_q + 1'b1;
            if (done_o || timeout_o || error_o)   armed_q <= 1'b0;
            else if (we_fell)                     armed_q <= 1'b1;
        end
    end

    p_wr_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (!ce_n_o && oe_n_o && dq_oe_o));

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && we_fell) |-> (dist_q <= DW'(GAP_MAX)));

    p_abort_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (ce_n_o && we_n_o && oe_n_o && !s_ready_o));

    p_poll_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> (!ce_n_o && we_n_o && !dq_oe_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_tout_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, timeout_o, error_o}));

    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (ce_n_o && we_n_o && oe_n_o));

endmodule

bind eeprom_page_writer eeprom_pw_checker #(
    .GAP_MAX (GAP_MAX)
) u_pw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n_o    (ce_n_o),
    .we_n_o    (we_n_o),
    .oe_n_o    (oe_n_o),
    .dq_oe_o   (dq_oe_o),
    .s_ready_o (s_ready_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .error_o   (error_o)
);

// File: tb/eeprom_page_writer_bench.sv
`timescale 1ns/1ps
module eeprom_page_writer_bench;
    localparam int AW = 10, PB = 16, LW = 4;
    localparam int SETUP = 2, PULSE = 3, RDC = 2, GAPM = 12, POLLM = 6;

    typedef struct packed {
        logic [9:0] base;
        logic [3:0] len;
        logic [3:0] busy;
        logic [1:0] res;   // 1 done, 2 timeout
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{10'h040, 4'd0,  4'd0, 2'd1},
        '{10'h100, 4'd15, 4'd3, 2'd1},
        '{10'h080, 4'd4,  4'd5, 2'd1},
        '{10'h200, 4'd7,  4'd6, 2'd2},
        '{10'h3F0, 4'd2,  4'd2, 2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, s_valid_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [LW-1:0] len_m1_i = '0;
    logic [7:0] s_data_i = '0;
    logic s_ready_o, ce_n_o, we_n_o, oe_n_o, dq_oe_o, poll_bit_i;
    logic done_o, timeout_o, error_o;
    logic [AW-1:0] addr_o;
    logic [7:0] dq_o;

    always #2 clk = ~clk;

    eeprom_page_writer #(
        .AW(AW), .PAGE_BYTES(PB), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
        .RD_CYC(RDC), .GAP_MAX(GAPM), .POLL_MAX(POLLM)
    ) u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .len_m1_i(len_m1_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i),
        .s_ready_o(s_ready_o), .ce_n_o(ce_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
        .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .poll_bit_i(poll_bit_i),
        .done_o(done_o), .timeout_o(timeout_o), .error_o(error_o)
    );

    // memory model, all state owned by this one process
    logic [7:0] mem [0:(1<<AW)-1];
    logic [7:0] last_wr = '0;
    logic [AW-1:0] last_wa = '0, addr_exp = '0, prev_addr = '0;
    logic [7:0] prev_dq = '0;
    logic prev_we = 1'b1, prev_oe = 1'b1, page_open = 1'b0, armed = 1'b0;
    int busy_cfg = 0, busy_left = 0, wr_cnt = 0, poll_cnt = 0;
    int setup_run = 0, pulse_run = 0, gap_run = 0;
    bit setup_bad = 0, pulse_bad = 0, gap_bad = 0, addr_bad = 0, rd_bad = 0;

    assign poll_bit_i = (busy_left != 0) ? ~last_wr[7] : mem[addr_o][7];

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_i && !page_open) begin
                page_open = 1'b1; addr_exp = base_i; busy_left = busy_cfg; armed = 1'b0;
            end
            if (prev_we && !we_n_o) begin
                if (setup_run != SETUP) setup_bad = 1;
                if (armed && gap_run > GAPM) gap_bad = 1;
                armed = 1'b1; gap_run = 0;
            end
            if (!prev_we && we_n_o) begin
                mem[prev_addr] = prev_dq; last_wr = prev_dq; last_wa = prev_addr;
                if (prev_addr != addr_exp) addr_bad = 1;
                addr_exp = addr_exp + 1'b1; wr_cnt++;
                if (pulse_run != PULSE) pulse_bad = 1;
            end
            if (!prev_oe && oe_n_o) begin
                poll_cnt++;
                if (busy_left > 0) busy_left--;
            end
            if (!ce_n_o && !oe_n_o && (addr_o != last_wa || dq_oe_o || !we_n_o)) rd_bad = 1;
            if (done_o || timeout_o || error_o) begin page_open = 1'b0; armed = 1'b0; end
            pulse_run = !we_n_o ? pulse_run + 1 : 0;
            setup_run = (!ce_n_o && we_n_o && oe_n_o) ? setup_run + 1 : 0;
            gap_run++;
            prev_we = we_n_o; prev_oe = oe_n_o; prev_addr = addr_o; prev_dq = dq_o;
        end
    end

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int base, input int j);
        return 8'(base * 3 + j * 29 + 8'h5A);
    endfunction

    // kind: 1 done, 2 timeout, 3 error
    task automatic run_page(input int base, input int len, input int busy,
                            input int first_stall, input int stall_at, input int stall_n,
                            input bit again, output int kind);
        bit aborted = 0;
        busy_cfg = busy;
        start_i = 1'b1; base_i = AW'(base); len_m1_i = LW'(len);
        @(negedge clk); start_i = 1'b0;
        for (int j = 0; j <= len; j++) begin
            int st;
            while (!s_ready_o && !error_o) @(negedge clk);
            st = (j == 0) ? first_stall : ((j == stall_at) ? stall_n : 0);
            for (int k = 0; k < st && !error_o; k++) @(negedge clk);
            if (error_o) begin aborted = 1; break; end
            s_valid_i = 1'b1; s_data_i = pat(base, j);
            @(negedge clk); s_valid_i = 1'b0;
            if (j == len && again) begin
                start_i = 1'b1; base_i = '0; len_m1_i = '1;
                @(negedge clk); start_i = 1'b0;
            end
        end
        kind = 0;
        if (aborted) kind = 3;
        for (int t = 0; t < 500 && kind == 0; t++) begin
            if (done_o) kind = 1;
            else if (timeout_o) kind = 2;
            else if (error_o) kind = 3;
            else @(negedge clk);
        end
    endtask

    task automatic check_data(input int base, input int len, input string req);
        int bad = 0;
        for (int j = 0; j <= len; j++)
            if (mem[AW'(base + j)] !== pat(base, j)) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        int kind, w0, p0, exp_polls;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(ce_n_o && we_n_o && oe_n_o, "R10 strobes", {ce_n_o, we_n_o, oe_n_o}, 7);
        check(!dq_oe_o && !s_ready_o, "R10 drive/ready", {dq_oe_o, s_ready_o}, 0);
        check(!done_o && !timeout_o && !error_o, "R10 flags", {done_o, timeout_o, error_o}, 0);

        for (int v = 0; v < 5; v++) begin
            w0 = wr_cnt; p0 = poll_cnt;
            run_page(int'(VEC[v].base), int'(VEC[v].len), int'(VEC[v].busy), 0, 0, 0, 1'b1, kind);
            exp_polls = (VEC[v].busy < POLLM) ? int'(VEC[v].busy) + 1 : POLLM;
            check(kind == int'(VEC[v].res), "R7/R8 result", kind, int'(VEC[v].res));
            check(wr_cnt - w0 == int'(VEC[v].len) + 1, "R1 write count", wr_cnt - w0, int'(VEC[v].len) + 1);
            check_data(int'(VEC[v].base), int'(VEC[v].len), "R1 data");
            @(negedge clk);
            check(poll_cnt - p0 == exp_polls, "R7/R8 poll reads", poll_cnt - p0, exp_polls);
            repeat (8) @(negedge clk);
            check(wr_cnt - w0 == int'(VEC[v].len) + 1 && !s_ready_o, "R9 restart ignored",
                  wr_cnt - w0, int'(VEC[v].len) + 1);
        end

        // R11 long wait before first byte, R5 stall that just meets the limit
        w0 = wr_cnt;
        run_page(10'h300, 3, 1, 20, 2, 6, 1'b0, kind);
        check(kind == 1, "R11/R5 stall within limit", kind, 1);
        check(wr_cnt - w0 == 4, "R11 writes", wr_cnt - w0, 4);
        check_data(10'h300, 3, "R5 data after stall");

        // R5 stall one cycle over the limit
        repeat (3) @(negedge clk);
        w0 = wr_cnt; p0 = poll_cnt;
        run_page(10'h320, 4, 0, 0, 2, 7, 1'b0, kind);
        check(kind == 3, "R5 underrun error", kind, 3);
        repeat (10) @(negedge clk);
        check(wr_cnt - w0 == 2, "R5 writes before abort", wr_cnt - w0, 2);
        check(poll_cnt == p0, "R5 no poll after abort", poll_cnt - p0, 0);
        check(ce_n_o && we_n_o && !s_ready_o, "R5 idle after abort", {ce_n_o, we_n_o, s_ready_o}, 6);

        // recovery page
        w0 = wr_cnt;
        run_page(10'h340, 1, 0, 0, 0, 0, 1'b0, kind);
        check(kind == 1 && wr_cnt - w0 == 2, "R1 page after abort", kind, 1);
        repeat (4) @(negedge clk);

        check(!setup_bad, "R3 setup width", setup_bad, 0);
        check(!pulse_bad, "R3 pulse width", pulse_bad, 0);
        check(!gap_bad, "R4 pulse gap", gap_bad, 0);
        check(!addr_bad, "R1 address order", addr_bad, 0);
        check(!rd_bad, "R6 poll read pins", rd_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule